// File: doc/BRIEF.md
# ALU Status Flag Generator

This is a purely combinational arithmetic and logic unit that works on byte, halfword (16-bit) and word (32-bit) operands and, alongside its result, derives six status flags: carry, even parity, auxiliary (nibble) carry, zero, sign and signed overflow. A datapath feeds it an operation code, a size code, two operands and the current carry flag. It takes the result, a write-back enable and the new flag values in the same cycle.

The arithmetic group covers plain and carry-chained addition and subtraction, increment, decrement, two's-complement negation and compare. The logical group covers AND, OR, XOR, invert and test. Compare and test produce flags exactly like subtract and AND but hold the write-back enable low. Every flag is taken at the active operand size, so a byte operation on a 32-bit operand ignores the upper 24 operand bits and returns them as zero.

Top module: `alu_status_core`

## Requirements
- R1: Opcode 0 adds opa_i+opb_i and opcode 1 adds opa_i+opb_i+carry_i. Result bits above the active size are zero, and operand bits above the active size have no effect on any output.
- R2: Opcode 2 gives opa_i-opb_i, opcode 3 gives opa_i-opb_i-carry_i, and opcode 6 gives 0-opa_i. All are computed modulo 2^size.
- R3: Opcode 4 gives opa_i+1 and opcode 5 gives opa_i-1. For both, flag_c_o equals carry_i, and the other five flags follow the result.
- R4: For opcodes 0, 1, 2, 3, 6 and 7, flag_c_o is 1 exactly when the top bit at the active size produces a carry (addition) or a borrow (subtraction).
- R5: For arithmetic opcodes, flag_a_o is 1 exactly when bit 3 carries into bit 4 (addition) or borrows from it (subtraction).
- R6: For arithmetic opcodes, flag_o_o is 1 exactly when the signed result at the active size is out of range. For logical opcodes it is 0.
- R7: flag_z_o is 1 exactly when the result at the active size is zero.
- R8: flag_s_o equals the most significant result bit at the active size.
- R9: flag_p_o is 1 when result bits [7:0] hold an even number of ones. Higher bits are not counted.
- R10: Opcodes 8 (AND), 9 (OR), 10 (XOR), 11 (invert opa_i) and 12 (test) force flag_c_o, flag_o_o and flag_a_o to 0.
- R11: Opcode 7 (compare) computes opa_i-opb_i and opcode 12 (test) computes opa_i&opb_i. Both drive result_o and all flags but hold wr_en_o at 0. All other defined opcodes (0 to 11) set wr_en_o to 1.
- R12: size_i selects the operand size: 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. A size wider than MAX_W is clamped to MAX_W.
- R13: Opcodes 13 to 15 are reserved. They give result 0 and wr_en_o 0. flag_z_o and flag_p_o are 1, and the other four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (R1 to R13 encodings) |
| size_i | input | 2 | Operand size code |
| opa_i | input | MAX_W | First operand |
| opb_i | input | MAX_W | Second operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | MAX_W | Result, zero above the active size |
| wr_en_o | output | 1 | Result write-back enable |
| flag_c_o | output | 1 | Carry / borrow |
| flag_p_o | output | 1 | Even parity of result bits [7:0] |
| flag_a_o | output | 1 | Carry or borrow across bit 3 |
| flag_z_o | output | 1 | Result is zero |
| flag_s_o | output | 1 | Result sign bit |
| flag_o_o | output | 1 | Signed overflow |

## Verification
The bench builds the block with the default MAX_W of 32. This generates all three adder lanes, so byte, halfword and word carry, overflow and sign positions can each be reached, and size code 3 can be compared against size code 2. The vectors place stray ones above the active size so that masking can be observed. They pair the signed and unsigned limits (0x7F, 0x80, 0xFF, 0x8000, 0x7FFFFFFF) to separate carry from overflow. A full sweep of one byte operand against a fixed addend checks carry and zero against a reference computed in the bench.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   localparam int LANES = 3;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_INC  = 4'd4,
      OP_DEC  = 4'd5,
      OP_NEG  = 4'd6,
      OP_CMP  = 4'd7,
      OP_AND  = 4'd8,
      OP_OR   = 4'd9,
      OP_XOR  = 4'd10,
      OP_NOT  = 4'd11,
      OP_TEST = 4'd12
   } alu_op_e;

   typedef enum logic [1:0] {
      LF_AND = 2'd0,
      LF_OR  = 2'd1,
      LF_XOR = 2'd2,
      LF_INV = 2'd3
   } logic_fn_e;

   // Lane index 0/1/2 = 8/16/32 bits; code 3 aliases lane 2; clamp to the widest built lane
   function automatic logic [1:0] lane_of(input logic [1:0] sz, input logic [1:0] top_lane);
      logic [1:0] l;
      l = (sz == 2'd3) ? 2'd2 : sz;
      if (l > top_lane) l = top_lane;
      return l;
   endfunction

endpackage

// File: rtl/alu_arith_lane.sv
module alu_arith_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         inv_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         aux_o,
   output logic         ovf_o
);

   logic [W-1:0] b_eff;
   logic [W:0]   wide;
   logic [4:0]   nib;

   always_comb begin
      b_eff  = inv_i ? ~b_i : b_i;
      wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
      nib    = {1'b0, a_i[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, cin_i};
      sum_o  = wide[W-1:0];
      // subtraction runs as a + ~b + 1, so carry-out inverted is the borrow
      cout_o = wide[W] ^ inv_i;
      aux_o  = nib[4] ^ inv_i;
      ovf_o  = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
   end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_flag_pkg::*;
#(
   parameter int W = 32
) (
   input  logic_fn_e    fn_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);

   always_comb begin
      unique case (fn_i)
         LF_AND:  y_o = a_i & b_i;
         LF_OR:   y_o = a_i | b_i;
         LF_XOR:  y_o = a_i ^ b_i;
         default: y_o = ~a_i;
      endcase
   end

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
   parameter int W = 32
) (
   input  logic [W-1:0] res_i,
   input  logic [1:0]   lane_i,
   output logic         zero_o,
   output logic         sign_o,
   output logic         par_o
);

   localparam int IDXW = $clog2(W);

   logic [IDXW-1:0] msb_idx;

   always_comb begin
      msb_idx = IDXW'((8 << lane_i) - 1);
      zero_o  = (res_i == '0);
      sign_o  = res_i[msb_idx];
      par_o   = ~^res_i[7:0];
   end

endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
   import alu_flag_pkg::*;
#(
   parameter int MAX_W = 32
) (
   input  logic [3:0]       op_i,
   input  logic [1:0]       size_i,
   input  logic [MAX_W-1:0] opa_i,
   input  logic [MAX_W-1:0] opb_i,
   input  logic             carry_i,
   output logic [MAX_W-1:0] result_o,
   output logic             wr_en_o,
   output logic             flag_c_o,
   output logic             flag_p_o,
   output logic             flag_a_o,
   output logic             flag_z_o,
   output logic             flag_s_o,
   output logic             flag_o_o
);

   localparam logic [1:0] TOP_LANE = (MAX_W == 32) ? 2'd2 : (MAX_W == 16) ? 2'd1 : 2'd0;

   if (!(MAX_W == 8 || MAX_W == 16 || MAX_W == 32)) begin : g_bad_width
      $error("alu_status_core: MAX_W must be 8, 16 or 32");
   end

   alu_op_e          op;
   logic [1:0]       lane;
   logic [MAX_W-1:0] src_a, src_b, size_mask, logic_y, res;
   logic             inv_b, cin, is_arith, is_logic, keep_c, writes;
   logic_fn_e        lfn;

   logic [MAX_W-1:0] lane_sum [LANES];
   logic [LANES-1:0] lane_c, lane_a, lane_o;
   logic             z_f, s_f, p_f;

   assign op   = alu_op_e'(op_i);
   assign lane = lane_of(size_i, TOP_LANE);

   // operand routing and operation class
   always_comb begin
      src_a    = opa_i;
      src_b    = opb_i;
      inv_b    = 1'b0;
      cin      = 1'b0;
      is_arith = 1'b1;
      is_logic = 1'b0;
      keep_c   = 1'b0;
      writes   = 1'b1;
      lfn      = LF_AND;
      case (op)
         OP_ADD:  ;
         OP_ADC:  cin = carry_i;
         OP_SUB:  begin inv_b = 1'b1; cin = 1'b1; end
         OP_SBB:  begin inv_b = 1'b1; cin = ~carry_i; end
         OP_INC:  begin src_b = MAX_W'(1); keep_c = 1'b1; end
         OP_DEC:  begin src_b = MAX_W'(1); inv_b = 1'b1; cin = 1'b1; keep_c = 1'b1; end
         OP_NEG:  begin src_a = '0; src_b = opa_i; inv_b = 1'b1; cin = 1'b1; end
         OP_CMP:  begin inv_b = 1'b1; cin = 1'b1; writes = 1'b0; end
         OP_AND:  begin is_arith = 1'b0; is_logic = 1'b1; lfn = LF_AND; end
         OP_OR:   begin is_arith = 1'b0; is_logic = 1'b1; lfn = LF_OR;  end
         OP_XOR:  begin is_arith = 1'b0; is_logic = 1'b1; lfn = LF_XOR; end
         OP_NOT:  begin is_arith = 1'b0; is_logic = 1'b1; lfn = LF_INV; end
         OP_TEST: begin is_arith = 1'b0; is_logic = 1'b1; lfn = LF_AND; writes = 1'b0; end
         default: begin is_arith = 1'b0; writes = 1'b0; end
      endcase
   end

   // one adder per supported width; unbuilt lanes tie off
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int LW = 8 << l;
      if (LW <= MAX_W) begin : g_on
         logic [LW-1:0] s;
         alu_arith_lane #(.W(LW)) u_lane (
            .a_i   (src_a[LW-1:0]),
            .b_i   (src_b[LW-1:0]),
            .inv_i (inv_b),
            .cin_i (cin),
            .sum_o (s),
            .cout_o(lane_c[l]),
            .aux_o (lane_a[l]),
            .ovf_o (lane_o[l])
         );
         assign lane_sum[l] = MAX_W'(s);
      end else begin : g_off
         assign lane_sum[l] = '0;
         assign lane_c[l]   = 1'b0;
         assign lane_a[l]   = 1'b0;
         assign lane_o[l]   = 1'b0;
      end
   end

   alu_logic_unit #(.W(MAX_W)) u_logic (
      .fn_i(lfn),
      .a_i (opa_i),
      .b_i (opb_i),
      .y_o (logic_y)
   );

   always_comb begin
      for (int i = 0; i < MAX_W; i++) size_mask[i] = (i < (8 << lane));
      if (is_arith)      res = lane_sum[lane];
      else if (is_logic) res = logic_y & size_mask;
      else               res = '0;
   end

   alu_flag_eval #(.W(MAX_W)) u_flags (
      .res_i (res),
      .lane_i(lane),
      .zero_o(z_f),
      .sign_o(s_f),
      .par_o (p_f)
   );

   assign result_o = res;
   assign wr_en_o  = writes;
   assign flag_c_o = is_arith ? (keep_c ? carry_i : lane_c[lane]) : 1'b0;
   assign flag_a_o = is_arith & lane_a[lane];
   assign flag_o_o = is_arith & lane_o[lane];
   assign flag_z_o = z_f;
   assign flag_s_o = s_f;
   assign flag_p_o = p_f;

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
   parameter int MAX_W = 32
) (
   input logic [3:0]       op_i,
   input logic [1:0]       size_i,
   input logic             carry_i,
   input logic [MAX_W-1:0] result_o,
   input logic             wr_en_o,
   input logic             flag_c_o,
   input logic             flag_p_o,
   input logic             flag_a_o,
   input logic             flag_z_o,
   input logic             flag_s_o,
   input logic             flag_o_o
);

   int unsigned bits;

   always_comb begin
      bits = (size_i == 2'd0) ? 8 : (size_i == 2'd1) ? 16 : 32;
      if (bits > MAX_W) bits = MAX_W;

      // R3
      carry_hold_chk: assert (!(op_i == 4'd4 || op_i == 4'd5) || flag_c_o == carry_i)
         else $error("carry not preserved on inc/dec");
      // R7
      zero_match_chk: assert (flag_z_o == (result_o == '0))
         else $error("zero flag disagrees with result");
      // R8
      sign_match_chk: assert (flag_s_o == result_o[bits-1])
         else $error("sign flag disagrees with result msb");
      // R9
      parity_match_chk: assert (flag_p_o == ~^result_o[7:0])
         else $error("parity flag disagrees with result");
      // R10
      logic_clear_chk: assert (op_i < 4'd8 || (!flag_c_o && !flag_o_o && !flag_a_o))
         else $error("logical op left carry/overflow/aux set");
      // R11
      no_write_chk: assert (!(op_i == 4'd7 || op_i >= 4'd12) || !wr_en_o)
         else $error("write-back enabled for a flags-only op");
      // R1
      upper_zero_chk: assert (bits == MAX_W || (result_o >> bits) == '0)
         else $error("result bits above active size not zero");
   end

endmodule

bind alu_status_core alu_status_chk #(.MAX_W(MAX_W)) u_chk (
   .op_i    (op_i),
   .size_i  (size_i),
   .carry_i (carry_i),
   .result_o(result_o),
   .wr_en_o (wr_en_o),
   .flag_c_o(flag_c_o),
   .flag_p_o(flag_p_o),
   .flag_a_o(flag_a_o),
   .flag_z_o(flag_z_o),
   .flag_s_o(flag_s_o),
   .flag_o_o(flag_o_o)
);

// File: tb/alu_status_core_bench.sv
module alu_status_core_bench;

   logic        clk = 1'b0;
   logic [3:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic [31:0] opa_i = '0, opb_i = '0;
   logic        carry_i = 1'b0;
   logic [31:0] result_o;
   logic        wr_en_o, flag_c_o, flag_p_o, flag_a_o, flag_z_o, flag_s_o, flag_o_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   alu_status_core #(.MAX_W(32)) u_alu_status_core (
      .op_i(op_i), .size_i(size_i), .opa_i(opa_i), .opb_i(opb_i), .carry_i(carry_i),
      .result_o(result_o), .wr_en_o(wr_en_o),
      .flag_c_o(flag_c_o), .flag_p_o(flag_p_o), .flag_a_o(flag_a_o),
      .flag_z_o(flag_z_o), .flag_s_o(flag_s_o), .flag_o_o(flag_o_o)
   );

   // entry: op4 size2 a32 b32 cin1 | result32 we1 flags6 {C,P,A,Z,S,O}
   localparam int NV = 27;
   localparam logic [109:0] VEC [NV] = '{
      {4'd0, 2'd0, 32'h0000007F, 32'h00000001, 1'b0, 32'h00000080, 1'b1, 6'b001011}, // R6 byte add ovf
      {4'd0, 2'd0, 32'h000000FF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 6'b111100}, // R4 byte carry
      {4'd1, 2'd0, 32'h00000010, 32'h00000020, 1'b1, 32'h00000031, 1'b1, 6'b000000}, // R1 adc
      {4'd2, 2'd0, 32'h00000000, 32'h00000001, 1'b0, 32'h000000FF, 1'b1, 6'b111010}, // R2 borrow
      {4'd2, 2'd0, 32'h00000080, 32'h00000001, 1'b0, 32'h0000007F, 1'b1, 6'b001001}, // R6 sub ovf
      {4'd3, 2'd0, 32'h00000005, 32'h00000005, 1'b1, 32'h000000FF, 1'b1, 6'b111010}, // R2 sbb
      {4'd4, 2'd0, 32'h000000FF, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 6'b111100}, // R3 inc keeps C=1
      {4'd4, 2'd0, 32'h0000007F, 32'h00000000, 1'b0, 32'h00000080, 1'b1, 6'b001011}, // R3 inc ovf
      {4'd5, 2'd1, 32'h00008000, 32'h00000000, 1'b1, 32'h00007FFF, 1'b1, 6'b111001}, // R3 dec word
      {4'd6, 2'd0, 32'h00000001, 32'h00000000, 1'b0, 32'h000000FF, 1'b1, 6'b111010}, // R2 neg 1
      {4'd6, 2'd0, 32'h00000080, 32'h00000000, 1'b0, 32'h00000080, 1'b1, 6'b100011}, // R6 neg min
      {4'd6, 2'd0, 32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 6'b010100}, // R4 neg 0
      {4'd7, 2'd1, 32'h00001234, 32'h00001234, 1'b0, 32'h00000000, 1'b0, 6'b010100}, // R11 cmp eq
      {4'd7, 2'd0, 32'h00000001, 32'h00000002, 1'b0, 32'h000000FF, 1'b0, 6'b111010}, // R11 cmp lt
      {4'd8, 2'd2, 32'hF0F000FF, 32'hFF000F0F, 1'b1, 32'hF000000F, 1'b1, 6'b010010}, // R10 and
      {4'd9, 2'd1, 32'hFFFF0000, 32'h12340000, 1'b1, 32'h00000000, 1'b1, 6'b010100}, // R10 or masked
      {4'd10,2'd0, 32'h000000AA, 32'h0000000F, 1'b0, 32'h000000A5, 1'b1, 6'b010010}, // R10 xor
      {4'd11,2'd0, 32'h0000000F, 32'h00000000, 1'b1, 32'h000000F0, 1'b1, 6'b010010}, // R10 not
      {4'd12,2'd2, 32'h80000000, 32'h80000001, 1'b1, 32'h80000000, 1'b0, 6'b010010}, // R11 test
      {4'd0, 2'd2, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 6'b111100}, // R4 word carry
      {4'd0, 2'd2, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b1, 6'b011011}, // R6 word ovf
      {4'd0, 2'd1, 32'h1234FFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 6'b111100}, // R12 half size
      {4'd0, 2'd3, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 6'b111100}, // R12 code 3
      {4'd13,2'd0, 32'h00000005, 32'h00000005, 1'b1, 32'h00000000, 1'b0, 6'b010100}, // R13 reserved
      {4'd0, 2'd0, 32'hABCDEF01, 32'h00000001, 1'b0, 32'h00000002, 1'b1, 6'b000000}, // R1 upper ignored
      {4'd3, 2'd1, 32'h00000000, 32'h0000FFFF, 1'b0, 32'h00000001, 1'b1, 6'b101000}, // R5 sbb word
      {4'd1, 2'd0, 32'h000000FF, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 6'b111100}  // R9 adc wrap
   };

   task automatic drive(input logic [3:0] op, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] b, input logic c);
      @(negedge clk);
      op_i = op; size_i = sz; opa_i = a; opb_i = b; carry_i = c;
      #2;
   endtask

   task automatic check(input string req, input logic [31:0] exp_res,
                        input logic exp_we, input logic [5:0] exp_fl);
      logic [5:0] got_fl;
      got_fl = {flag_c_o, flag_p_o, flag_a_o, flag_z_o, flag_s_o, flag_o_o};
      total++;
      if (result_o !== exp_res || wr_en_o !== exp_we || got_fl !== exp_fl) begin
         bad++;
         $display("FAIL %s: got res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
                  req, result_o, wr_en_o, got_fl, exp_res, exp_we, exp_fl);
      end
   endtask

   initial begin
      // reset-state style check: all-zero inputs are a byte add of zero (R7, R9)
      drive(4'd0, 2'd0, 32'h0, 32'h0, 1'b0);
      check("R7_idle", 32'h0, 1'b1, 6'b010100);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][109:106], VEC[i][105:104], VEC[i][103:72], VEC[i][71:40], VEC[i][39]);
         check($sformatf("vec%0d", i), VEC[i][38:7], VEC[i][6], VEC[i][5:0]);
      end

      // R4 / R7 sweep: byte add against a fixed addend with stray upper bits
      for (int a = 0; a < 256; a++) begin
         int s;
         logic [5:0] ef;
         logic [7:0] r8;
         s  = a + 8'h5A;
         r8 = s[7:0];
         ef = {s > 255, ~^r8, ((a & 15) + 10) > 15, r8 == 8'h0, r8[7],
               (a[7] == 1'b0) && (r8[7] == 1'b1)};
         drive(4'd0, 2'd0, 32'hC3000000 | a, 32'h0000005A, 1'b1);
         check("R4_sweep", {24'h0, r8}, 1'b1, ef);
      end

      // R8 halfword sign from bit 15, not bit 7 or 31
      drive(4'd9, 2'd1, 32'hFFFF8000, 32'h00000000, 1'b0);
      check("R8_half_sign", 32'h00008000, 1'b1, 6'b010010);

      // R3 dec with carry clear keeps C=0 even when a borrow occurs
      drive(4'd5, 2'd0, 32'h00000000, 32'h0, 1'b0);
      check("R3_dec_borrow", 32'h000000FF, 1'b1, 6'b011010);

      // R13 reserved code 15 ignores operands and carry
      drive(4'd15, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
      check("R13_code15", 32'h0, 1'b0, 6'b010100);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule